// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the software-visible register store of an interrupt routing controller. Two word-wide offsets face the processor bus: an 8-bit select register and a 32-bit data window. Software first writes the select register, then reads or writes the window. The window then reaches whichever internal register the select value names: an identification register, a version register, an arbitration register, or one 32-bit half of a per-pin 64-bit redirection entry.

Each redirection entry holds the routing of one input pin: vector, delivery mode, destination mode, delivery status, polarity, remote-IRR flag, trigger mode, mask and destination. The whole table is exposed in flattened form for the delivery logic. That logic owns the two status bits. It sets remote-IRR when it accepts a level interrupt, and it sets or clears delivery status while a message is in flight. Software writes leave both status bits alone.

After every accepted entry write, the block pulses a one-cycle strobe carrying the pin index. With that strobe it also reports whether the mask bit flipped, and whether a level-triggered pin with a pending input needs a fresh service attempt.

Top module: `irq_route_regfile`

## Requirements
- R1: A write with `acc_win`=0 loads the 8-bit select register from `acc_wdata[7:0]`. A read with `acc_win`=0 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, a window read returns (NPINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits 0. Window writes at select 0x01 change nothing.
- R3: With select 0x00, a window write stores `acc_wdata[27:24]` as a 4-bit identifier. Window reads at select 0x00 and at select 0x02 both return that identifier in bits 27:24, with all other bits 0.
- R4: For a select value s of 0x10 or above, the pin index is (s-0x10)>>1. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32. The entry of pin i appears at `tbl_flat[i*64 +: 64]`.
- R5: When the index from R4 is at or above NPINS, a window read returns 0xFFFFFFFF. A window write there changes no entry and raises no strobe.
- R6: A window write to an entry leaves delivery status (bit 12) and remote-IRR (bit 14) at their previous values, whatever the written data holds.
- R7: An entry whose trigger mode (bit 15, 1 = level) is 0 always has remote-IRR 0. This holds after a write that makes the entry edge-triggered, and when `rirr_set` is pulsed for an edge-triggered pin.
- R8: Reset sets the select register to 0 and the identifier to 0. It gives every entry mask (bit 16) = 1 and all other entry bits 0.
- R9: One cycle after an accepted entry write, `wr_stb` is 1 for exactly that cycle, with `wr_pin` holding the pin index.
- R10: With that strobe, `mask_chg_stb` is 1 exactly when the write flipped the entry's mask bit, and `mask_chg_val` is the new mask value.
- R11: With that strobe, `svc_req` is 1 exactly when the entry is level-triggered after the write and `pend_level` for that pin was 1 during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Bus access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_win | input | 1 | 0 = select register, 1 = data window |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for the addressed offset |
| pend_level | input | NPINS | Per-pin input request pending |
| rirr_set | input | NPINS | Delivery logic sets remote-IRR (level entries only) |
| dstat_set | input | NPINS | Delivery logic sets delivery status |
| dstat_clr | input | NPINS | Delivery logic clears delivery status |
| tbl_flat | output | NPINS*64 | Current table, pin i at bits i*64+63 : i*64 |
| wr_stb | output | 1 | Entry-written strobe |
| wr_pin | output | $clog2(NPINS) | Pin index of the written entry |
| mask_chg_stb | output | 1 | Mask bit changed by that write |
| mask_chg_val | output | 1 | New mask value |
| svc_req | output | 1 | Service attempt requested for `wr_pin` |

## Verification
A corrupted select register or a bad index decode shows up on the very next window access. The read returns data from the wrong entry, the wrong half of an entry, or all ones where real data was expected. A status bit lost or overwritten in the merge shows on `tbl_flat` one cycle after the write, and on the next window read of that half. Event logic that samples the wrong mask or the wrong trigger value shows up in the cycle after the write. `mask_chg_stb` or `svc_req` then disagrees with what the old and new entry contents demand.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_TBL_BASE = 8'h10;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        level;
        logic        rirr;
        logic        pol;
        logic        dstat;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } entry_t;

    localparam entry_t RST_ENTRY = '{mask: 1'b1, default: '0};

    // Replace one half of an entry; status bits follow their previous values,
    // and an edge-triggered result never keeps remote-IRR.
    function automatic entry_t entry_merge(entry_t cur, logic hi, logic [31:0] d);
        logic [63:0] b;
        entry_t      n;
        b = cur;
        if (hi) b[63:32] = d;
        else    b[31:0]  = d;
        n       = b;
        n.dstat = cur.dstat;
        n.rirr  = cur.rirr & n.level;
        return n;
    endfunction

endpackage

// File: rtl/irr_sel_decode.sv
module irr_sel_decode
    import irr_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IW    = 5
) (
    input  logic [7:0]    sel,
    output logic          is_id,
    output logic          is_ver,
    output logic          is_arb,
    output logic          is_ent,
    output logic          is_oor,
    output logic          hi_half,
    output logic [IW-1:0] ent_idx
);
    logic [7:0] off;
    logic [6:0] raw;
    logic       in_zone;

    always_comb begin
        off     = sel - SEL_TBL_BASE;
        raw     = off[7:1];
        in_zone = (sel >= SEL_TBL_BASE);
        is_id   = (sel == SEL_ID);
        is_ver  = (sel == SEL_VER);
        is_arb  = (sel == SEL_ARB);
        is_ent  = in_zone && ({1'b0, raw} < 8'(NPINS));
        is_oor  = in_zone && !is_ent;
        hi_half = sel[0];
        ent_idx = raw[IW-1:0];
    end
endmodule

// File: rtl/irr_table.sv
module irr_table
    import irr_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic             whi,
    input  logic [31:0]      wdata,
    input  logic [NPINS-1:0] rirr_set,
    input  logic [NPINS-1:0] dstat_set,
    input  logic [NPINS-1:0] dstat_clr,
    output entry_t           tbl [NPINS]
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        entry_t cur, nxt;
        assign cur = tbl[i];

        always_comb begin
            nxt = cur;
            if (we && (widx == IW'(i)))
                nxt = entry_merge(cur, whi, wdata);
            if (rirr_set[i] && nxt.level)
                nxt.rirr = 1'b1;
            if (dstat_set[i])
                nxt.dstat = 1'b1;
            else if (dstat_clr[i])
                nxt.dstat = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) tbl[i] <= RST_ENTRY;
            else     tbl[i] <= nxt;
        end
    end
endmodule

// File: rtl/irr_event.sv
module irr_event #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [IW-1:0] idx,
    input  logic          mask_old,
    input  logic          mask_new,
    input  logic          level_new,
    input  logic          pend,
    output logic          wr_stb,
    output logic [IW-1:0] wr_pin,
    output logic          mask_chg_stb,
    output logic          mask_chg_val,
    output logic          svc_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb       <= 1'b0;
            wr_pin       <= '0;
            mask_chg_stb <= 1'b0;
            mask_chg_val <= 1'b0;
            svc_req      <= 1'b0;
        end else begin
            wr_stb       <= fire;
            mask_chg_stb <= fire && (mask_old != mask_new);
            svc_req      <= fire && level_new && pend;
            if (fire) begin
                wr_pin       <= idx;
                mask_chg_val <= mask_new;
            end
        end
    end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irr_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int         IW      = $clog2(NPINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_win,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         rd_data,
    input  logic [NPINS-1:0]    pend_level,
    input  logic [NPINS-1:0]    rirr_set,
    input  logic [NPINS-1:0]    dstat_set,
    input  logic [NPINS-1:0]    dstat_clr,
    output logic [NPINS*64-1:0] tbl_flat,
    output logic                wr_stb,
    output logic [IW-1:0]       wr_pin,
    output logic                mask_chg_stb,
    output logic                mask_chg_val,
    output logic                svc_req
);
    logic [7:0]    sel_q;
    logic [3:0]    id_q;
    logic          is_id, is_ver, is_arb, is_ent, is_oor, hi_half;
    logic [IW-1:0] ent_idx;
    entry_t        tbl [NPINS];
    entry_t        cur_ent, nxt_ent;
    logic          wr_sel, wr_win, ent_we;

    assign wr_sel = acc_valid && acc_write && !acc_win;
    assign wr_win = acc_valid && acc_write &&  acc_win;
    assign ent_we = wr_win && is_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (wr_sel)
                sel_q <= acc_wdata[7:0];
            if (wr_win && is_id)
                id_q <= acc_wdata[27:24];
        end
    end

    irr_sel_decode #(.NPINS(NPINS), .IW(IW)) u_dec (
        .sel     (sel_q),
        .is_id   (is_id),
        .is_ver  (is_ver),
        .is_arb  (is_arb),
        .is_ent  (is_ent),
        .is_oor  (is_oor),
        .hi_half (hi_half),
        .ent_idx (ent_idx)
    );

    irr_table #(.NPINS(NPINS), .IW(IW)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .we        (ent_we),
        .widx      (ent_idx),
        .whi       (hi_half),
        .wdata     (acc_wdata),
        .rirr_set  (rirr_set),
        .dstat_set (dstat_set),
        .dstat_clr (dstat_clr),
        .tbl       (tbl)
    );

    always_comb begin
        cur_ent = is_ent ? tbl[ent_idx] : RST_ENTRY;
        nxt_ent = entry_merge(cur_ent, hi_half, acc_wdata);
    end

    irr_event #(.IW(IW)) u_evt (
        .clk          (clk),
        .rst          (rst),
        .fire         (ent_we),
        .idx          (ent_idx),
        .mask_old     (cur_ent.mask),
        .mask_new     (nxt_ent.mask),
        .level_new    (nxt_ent.level),
        .pend         (is_ent && pend_level[ent_idx]),
        .wr_stb       (wr_stb),
        .wr_pin       (wr_pin),
        .mask_chg_stb (mask_chg_stb),
        .mask_chg_val (mask_chg_val),
        .svc_req      (svc_req)
    );

    always_comb begin
        logic [63:0] eb;
        eb = cur_ent;
        if (!acc_win)
            rd_data = {24'h0, sel_q};
        else if (is_ent)
            rd_data = hi_half ? eb[63:32] : eb[31:0];
        else if (is_oor)
            rd_data = 32'hFFFF_FFFF;
        else if (is_id || is_arb)
            rd_data = {4'h0, id_q, 24'h0};
        else if (is_ver)
            rd_data = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
        else
            rd_data = 32'h0;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_flat
        assign tbl_flat[i*64 +: 64] = tbl[i];
    end
endmodule

// File: rtl/irr_route_chk.sv
module irr_route_chk #(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11,
    parameter int         IW      = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                acc_valid,
    input logic                acc_write,
    input logic                acc_win,
    input logic [31:0]         rd_data,
    input logic [7:0]          sel_q,
    input logic [NPINS-1:0]    dstat_set,
    input logic [NPINS-1:0]    dstat_clr,
    input logic [NPINS*64-1:0] tbl_flat,
    input logic                wr_stb,
    input logic [IW-1:0]       wr_pin,
    input logic                mask_chg_stb,
    input logic                svc_req
);
    logic [NPINS-1:0] masks;
    for (genvar i = 0; i < NPINS; i++) begin : g_m
        assign masks[i] = tbl_flat[i*64 + 16];
    end

    p_rst_state_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((&masks) && sel_q == 8'h00));

    p_ver_read_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_win && sel_q == 8'h01) |-> rd_data == {8'h00, 8'(NPINS - 1), 8'h00, VERSION});

    p_stb_cause_r9: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(acc_valid && acc_write && acc_win));

    p_mask_with_stb_r10: assert property (@(posedge clk) disable iff (rst)
        mask_chg_stb |-> wr_stb);

    p_svc_level_r11: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> (wr_stb && tbl_flat[int'(wr_pin)*64 + 15]));

    for (genvar i = 0; i < NPINS; i++) begin : g_pa
        p_edge_no_rirr_r7: assert property (@(posedge clk) disable iff (rst)
            !tbl_flat[i*64 + 15] |-> !tbl_flat[i*64 + 14]);

        p_dstat_kept_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_stb && wr_pin == IW'(i) && !$past(dstat_set[i]) && !$past(dstat_clr[i]))
            |-> tbl_flat[i*64 + 12] == $past(tbl_flat[i*64 + 12]));
    end
endmodule

bind irq_route_regfile irr_route_chk #(.NPINS(NPINS), .VERSION(VERSION), .IW(IW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_win      (acc_win),
    .rd_data      (rd_data),
    .sel_q        (sel_q),
    .dstat_set    (dstat_set),
    .dstat_clr    (dstat_clr),
    .tbl_flat     (tbl_flat),
    .wr_stb       (wr_stb),
    .wr_pin       (wr_pin),
    .mask_chg_stb (mask_chg_stb),
    .svc_req      (svc_req)
);

// File: tb/test_irq_route_regfile.sv
module test_irq_route_regfile;
    localparam int NP = 24;
    localparam int IW = $clog2(NP);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_win = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [NP-1:0] pend_level = '0, rirr_set = '0, dstat_set = '0, dstat_clr = '0;
    logic [NP*64-1:0] tbl_flat, snap;
    logic wr_stb, mask_chg_stb, mask_chg_val, svc_req;
    logic [IW-1:0] wr_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_route_regfile #(.NPINS(NP), .VERSION(8'h11)) i_irq_route_regfile (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_win(acc_win), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .pend_level(pend_level), .rirr_set(rirr_set), .dstat_set(dstat_set),
        .dstat_clr(dstat_clr), .tbl_flat(tbl_flat), .wr_stb(wr_stb),
        .wr_pin(wr_pin), .mask_chg_stb(mask_chg_stb), .mask_chg_val(mask_chg_val),
        .svc_req(svc_req)
    );

    // {write, window, data, expected read}
    localparam int NV = 20;
    localparam logic [65:0] VEC [NV] = '{
        {1'b1, 1'b0, 32'h0000_0001, 32'h0},          // R1 select version
        {1'b0, 1'b1, 32'h0,         32'h0017_0011},  // R2
        {1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0},          // R2 write ignored
        {1'b0, 1'b1, 32'h0,         32'h0017_0011},  // R2
        {1'b1, 1'b0, 32'h0000_0000, 32'h0},          // select id
        {1'b1, 1'b1, 32'hA500_0000, 32'h0},          // R3 store 4 bits
        {1'b0, 1'b1, 32'h0,         32'h0500_0000},  // R3
        {1'b1, 1'b0, 32'h0000_0002, 32'h0},          // select arb
        {1'b0, 1'b1, 32'h0,         32'h0500_0000},  // R3 arb view
        {1'b1, 1'b0, 32'h0000_0010, 32'h0},          // pin 0 low
        {1'b0, 1'b1, 32'h0,         32'h0001_0000},  // R8 masked after reset
        {1'b1, 1'b1, 32'h0000_5031, 32'h0},          // R6 status bits in data
        {1'b0, 1'b1, 32'h0,         32'h0000_0031},  // R6 status kept 0
        {1'b1, 1'b0, 32'h0000_0011, 32'h0},          // pin 0 high
        {1'b1, 1'b1, 32'hAB00_0000, 32'h0},          // R4
        {1'b0, 1'b1, 32'h0,         32'hAB00_0000},  // R4
        {1'b0, 1'b0, 32'h0,         32'h0000_0011},  // R1 select readback
        {1'b1, 1'b0, 32'h0000_0040, 32'h0},          // index 24
        {1'b0, 1'b1, 32'h0,         32'hFFFF_FFFF},  // R5
        {1'b1, 1'b0, 32'h0000_00FF, 32'h0}           // index 119
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic win, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_win = win; acc_wdata = d;
    endtask

    task automatic rd_check(input logic win, input logic [31:0] exp, input string tag);
        drive(1'b0, win, 32'h0);
        #1;
        chk(rd_data == exp, tag, 64'(rd_data), 64'(exp));
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic wr(input logic win, input logic [31:0] d);
        drive(1'b1, win, d);
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    function automatic logic [63:0] ent(input int p);
        return tbl_flat[p*64 +: 64];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R8 reset state
        begin
            logic allm;
            allm = 1'b1;
            for (int p = 0; p < NP; p++) if (ent(p) != 64'h0000_0000_0001_0000) allm = 1'b0;
            chk(allm, "R8 entries masked", ent(0), 64'h1_0000);
        end
        rd_check(1'b0, 32'h0, "R8 select zero");
        chk(wr_stb == 1'b0, "R9 idle strobe", 64'(wr_stb), 64'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][65]) wr(VEC[k][64], VEC[k][63:32]);
            else rd_check(VEC[k][64], VEC[k][31:0], $sformatf("R1-R8 vector %0d", k));
        end
        rd_check(1'b1, 32'hFFFF_FFFF, "R5 top select");

        // R9 R10 R11: level write with pending input, mask 1->0
        pend_level = NP'(1) << 3;
        wr(1'b0, 32'h16);
        wr(1'b1, 32'h0000_8042);
        chk(wr_stb && wr_pin == IW'(3), "R9 strobe pin", {wr_stb, 8'(wr_pin)}, {1'b1, 8'd3});
        chk(mask_chg_stb && !mask_chg_val, "R10 mask change", {mask_chg_stb, mask_chg_val}, 2'b10);
        chk(svc_req == 1'b1, "R11 service", 64'(svc_req), 64'h1);
        @(posedge clk); #1;
        chk(!wr_stb && !mask_chg_stb && !svc_req, "R9 single cycle",
            {wr_stb, mask_chg_stb, svc_req}, 3'b000);

        // R6 remote-IRR preserved on level rewrite; no mask event
        @(negedge clk); rirr_set = NP'(1) << 3;
        @(negedge clk); rirr_set = '0;
        chk(ent(3)[14] == 1'b1, "R7 level rirr set", 64'(ent(3)[14]), 64'h1);
        wr(1'b1, 32'h0000_8043);
        chk(!mask_chg_stb && svc_req, "R10 no mask change", {mask_chg_stb, svc_req}, 2'b01);
        rd_check(1'b1, 32'h0000_C043, "R6 rirr kept");

        // R7 edge write clears remote-IRR; R11 no service for edge
        pend_level = '0;
        wr(1'b1, 32'h0000_0043);
        chk(!svc_req && wr_stb, "R11 edge no service", {svc_req, wr_stb}, 2'b01);
        rd_check(1'b1, 32'h0000_0043, "R7 rirr cleared");

        // R11 level write without pending input
        wr(1'b1, 32'h0000_8043);
        chk(!svc_req, "R11 not pending", 64'(svc_req), 64'h0);
        wr(1'b1, 32'h0000_0043);

        // R6 delivery status preserved
        @(negedge clk); dstat_set = NP'(1) << 3;
        @(negedge clk); dstat_set = '0;
        wr(1'b1, 32'h0000_0000);
        rd_check(1'b1, 32'h0000_1000, "R6 dstat kept");

        // R4 odd select reaches upper half only
        wr(1'b0, 32'h17);
        wr(1'b1, 32'h1234_5678);
        chk(ent(3) == 64'h1234_5678_0000_1000, "R4 high half", ent(3), 64'h1234_5678_0000_1000);

        // R7 rirr_set ignored on an edge-triggered pin
        @(negedge clk); rirr_set = NP'(1) << 5;
        @(negedge clk); rirr_set = '0;
        chk(ent(5)[14] == 1'b0, "R7 edge ignores set", 64'(ent(5)[14]), 64'h0);

        // R5 write beyond pin count ignored
        snap = tbl_flat;
        wr(1'b0, 32'h40);
        wr(1'b1, 32'hFFFF_FFFF);
        chk(!wr_stb, "R5 no strobe", 64'(wr_stb), 64'h0);
        chk(tbl_flat == snap, "R5 table unchanged", ent(0), snap[63:0]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule